// File: doc/BRIEF.md
# Octal Latched Bidirectional Transceiver

This block passes 8-bit data between two buses, A and B, in either direction. Each direction owns a storage bank and three active-low controls: a chip enable, a latch enable and an output enable. The chip enable is needed both to load the bank and to drive the far bus. With the chip enable and latch enable low, the bank is transparent and the far bus follows the source bus. When the latch enable goes high, the bank keeps the last captured word. The far bus is driven only while the chip enable and output enable are both low.

Each bus pin is modelled as a data input, a data output and an active-high drive enable. The block therefore holds no tristate nets, and the pad buffers sit outside it. Storage is clocked: while a bank is transparent it captures its source word on every rising clock edge. While the bank is transparent, the far-bus output shows the live source word without passing through a register. A flag reports when both directions drive their outputs at once.

Top module: `octal_latched_xcvr`

## Requirements
- R1: An active-low asynchronous reset clears both storage banks to zero. With chip enable low, latch enable high and output enable low, each output then presents 0.
- R2: `b_oe` is 1 exactly when `ab_cen` and `ab_oen` are both 0. `a_oe` is 1 exactly when `ba_cen` and `ba_oen` are both 0.
- R3: While `ab_cen` is 1, `b_oe` is 0 whatever `ab_len`, `ab_oen` and `a_in` are. The same holds for `ba_cen` and `a_oe`.
- R4: While `ab_cen`, `ab_len` and `ab_oen` are all 0, `b_out` equals `a_in` in the same cycle.
- R5: While `ab_cen` is 0 and `ab_len` is 1, the A-to-B bank keeps its value, and `b_out` presents the `a_in` word sampled at the last rising clock edge at which the bank was transparent.
- R6: While `ab_cen` is 1, the A-to-B bank loads nothing, even with `ab_len` at 0. After the chip enable returns low with `ab_len` high, the old value is presented.
- R7: The B-to-A direction behaves as in R4 to R6 with `ba_cen`, `ba_len` and `ba_oen`, storing from `b_in` and driving `a_out`.
- R8: `contention` is 1 exactly when `a_oe` and `b_oe` are both 1.
- R9: The controls of one direction have no effect on the bank or the outputs of the other direction.
- R10: Whenever an output's drive enable is 0, its data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock for both banks |
| rst_n | input | 1 | Asynchronous active-low reset of both banks |
| a_in | input | 8 | Word sensed on bus A |
| a_out | output | 8 | Word to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 8 | Word sensed on bus B |
| b_out | output | 8 | Word to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |
| ab_cen | input | 1 | A-to-B chip enable, active low |
| ab_len | input | 1 | A-to-B latch enable, active low (low = transparent) |
| ab_oen | input | 1 | A-to-B output enable, active low |
| ba_cen | input | 1 | B-to-A chip enable, active low |
| ba_len | input | 1 | B-to-A latch enable, active low (low = transparent) |
| ba_oen | input | 1 | B-to-A output enable, active low |
| contention | output | 1 | Both directions driving at once |

## Verification
Both directions can drive in the same cycle, and each bank can load or hold while the other does something different. Random control vectors lean towards chip enables at 0, so that cycles in which both outputs are enabled occur often. Directed cases also set one bank transparent while the other holds. In each such cycle, the bench compares `contention`, both drive enables and both data words with a per-direction model, so a fault that couples the two directions shows up as a mismatch on the other bus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int NUM_DIRS = 2;
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;

  // bank follows its source bus
  function automatic logic is_transparent(input logic cen, input logic len);
    return (cen == 1'b0) && (len == 1'b0);
  endfunction

  // far bus is driven
  function automatic logic is_driving(input logic cen, input logic oen);
    return (cen == 1'b0) && (oen == 1'b0);
  endfunction

  // word shown by the bank
  function automatic logic [7:0] bank_view(input logic transparent,
                                           input logic [7:0] live,
                                           input logic [7:0] stored);
    return transparent ? live : stored;
  endfunction
endpackage

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl (
  input  logic cen,
  input  logic len,
  input  logic oen,
  output logic load,
  output logic drive
);
  import xcvr_pkg::*;
  always_comb begin
    load  = is_transparent(cen, len);
    drive = is_driving(cen, oen);
  end
endmodule

// File: rtl/xcvr_bank.sv
module xcvr_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] held,
  output logic [W-1:0] view
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= din;
  end

  always_comb view = load ? din : held;
endmodule

// File: rtl/xcvr_out_gate.sv
module xcvr_out_gate #(
  parameter int W = 8
) (
  input  logic         drive,
  input  logic [W-1:0] view,
  output logic [W-1:0] dout,
  output logic         oe
);
  always_comb begin
    oe   = drive;
    dout = drive ? view : '0;
  end
endmodule

// File: rtl/octal_latched_xcvr.sv
module octal_latched_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ab_cen,
  input  logic         ab_len,
  input  logic         ab_oen,
  input  logic         ba_cen,
  input  logic         ba_len,
  input  logic         ba_oen,
  output logic         contention
);
  import xcvr_pkg::*;

  logic [NUM_DIRS-1:0]        cen_v, len_v, oen_v, load_v, drive_v, oe_v;
  logic [NUM_DIRS-1:0][W-1:0] src_v, held_v, view_v, out_v;

  // named internal events for the checker
  logic         ab_load, ba_load;
  logic [W-1:0] ab_held, ba_held;

  always_comb begin
    cen_v[DIR_AB] = ab_cen;  len_v[DIR_AB] = ab_len;  oen_v[DIR_AB] = ab_oen;
    cen_v[DIR_BA] = ba_cen;  len_v[DIR_BA] = ba_len;  oen_v[DIR_BA] = ba_oen;
    src_v[DIR_AB] = a_in;
    src_v[DIR_BA] = b_in;
  end

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    xcvr_dir_ctrl u_ctrl (
      .cen   (cen_v[d]),
      .len   (len_v[d]),
      .oen   (oen_v[d]),
      .load  (load_v[d]),
      .drive (drive_v[d])
    );
    xcvr_bank #(.W(W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_v[d]),
      .din   (src_v[d]),
      .held  (held_v[d]),
      .view  (view_v[d])
    );
    xcvr_out_gate #(.W(W)) u_gate (
      .drive (drive_v[d]),
      .view  (view_v[d]),
      .dout  (out_v[d]),
      .oe    (oe_v[d])
    );
  end

  always_comb begin
    b_out      = out_v[DIR_AB];
    b_oe       = oe_v[DIR_AB];
    a_out      = out_v[DIR_BA];
    a_oe       = oe_v[DIR_BA];
    ab_load    = load_v[DIR_AB];
    ba_load    = load_v[DIR_BA];
    ab_held    = held_v[DIR_AB];
    ba_held    = held_v[DIR_BA];
    contention = oe_v[DIR_AB] & oe_v[DIR_BA];
  end
endmodule

// File: rtl/octal_latched_xcvr_chk.sv
module octal_latched_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe,
  input logic         ab_cen,
  input logic         ab_len,
  input logic         ab_oen,
  input logic         ba_cen,
  input logic         ba_len,
  input logic         ba_oen,
  input logic         contention,
  input logic         ab_load,
  input logic         ba_load,
  input logic [W-1:0] ab_held,
  input logic [W-1:0] ba_held
);
  p_ab_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_cen && !ab_oen) |-> b_oe);
  p_ab_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ab_cen |-> !b_oe);
  p_ba_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ba_cen |-> !a_oe);
  p_ab_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_cen && !ab_len && !ab_oen) |-> (b_out == a_in));
  p_ab_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_load |=> (ab_held == $past(ab_held)));
  p_ab_noload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ab_cen |-> !ab_load);
  p_ba_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_cen && !ba_len && !ba_oen) |-> (a_out == b_in));
  p_ba_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ba_load |=> (ba_held == $past(ba_held)));
  p_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    contention == (a_oe && b_oe));
  p_ab_indep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_cen && !ba_load) |=> (ba_held == $past(ba_held)));
  p_b_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !b_oe |-> (b_out == '0));
  p_a_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !a_oe |-> (a_out == '0));
endmodule

bind octal_latched_xcvr octal_latched_xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe),
  .ab_cen(ab_cen), .ab_len(ab_len), .ab_oen(ab_oen),
  .ba_cen(ba_cen), .ba_len(ba_len), .ba_oen(ba_oen),
  .contention(contention), .ab_load(ab_load), .ba_load(ba_load),
  .ab_held(ab_held), .ba_held(ba_held)
);

// File: tb/octal_latched_xcvr_bench.sv
module octal_latched_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe, contention;
  logic ab_cen = 1'b1, ab_len = 1'b1, ab_oen = 1'b1;
  logic ba_cen = 1'b1, ba_len = 1'b1, ba_oen = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  octal_latched_xcvr #(.W(W)) u_octal_latched_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_cen(ab_cen), .ab_len(ab_len), .ab_oen(ab_oen),
    .ba_cen(ba_cen), .ba_len(ba_len), .ba_oen(ba_oen),
    .contention(contention)
  );

  function automatic logic m_en(input logic cen, input logic oen);
    return !(cen | oen);
  endfunction

  function automatic logic [W-1:0] m_word(input logic cen, input logic len, input logic oen,
                                          input logic [W-1:0] live, input logic [W-1:0] st);
    if (cen || oen) return '0;
    return len ? st : live;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 b_oe"}, W'(b_oe), W'(m_en(ab_cen, ab_oen)));
    chk({tag, " R2 a_oe"}, W'(a_oe), W'(m_en(ba_cen, ba_oen)));
    chk({tag, " R4/R5/R10 b_out"}, b_out, m_word(ab_cen, ab_len, ab_oen, a_in, m_ab));
    chk({tag, " R7/R10 a_out"}, a_out, m_word(ba_cen, ba_len, ba_oen, b_in, m_ba));
    chk({tag, " R8 contention"}, W'(contention),
        W'(m_en(ab_cen, ab_oen) & m_en(ba_cen, ba_oen)));
  endtask

  // apply at negedge, check shortly after, model captures at next posedge
  task automatic step(input string tag,
                      input logic [W-1:0] av, input logic [W-1:0] bv,
                      input logic [2:0] abc, input logic [2:0] bac);
    @(negedge clk);
    a_in = av; b_in = bv;
    {ab_cen, ab_len, ab_oen} = abc;
    {ba_cen, ba_len, ba_oen} = bac;
    #1;
    check_all(tag);
    if (!ab_cen && !ab_len) m_ab = a_in;
    if (!ba_cen && !ba_len) m_ba = b_in;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state, held path enabled
    @(negedge clk);
    a_in = 8'hA5; b_in = 8'h3C;
    {ab_cen, ab_len, ab_oen} = 3'b010;
    {ba_cen, ba_len, ba_oen} = 3'b010;
    #1;
    chk("R1 b_out in reset", b_out, 8'h00);
    chk("R1 a_out in reset", a_out, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 b_out after reset", b_out, 8'h00);
    chk("R1 a_out after reset", a_out, 8'h00);

    // R4 transparent, then R5 hold
    step("R4 pass", 8'h11, 8'h00, 3'b000, 3'b111);
    step("R4 pass2", 8'h5A, 8'h00, 3'b000, 3'b111);
    step("R5 hold", 8'hFF, 8'h00, 3'b010, 3'b111);
    chk("R5 b_out keeps stored", b_out, 8'h5A);
    step("R5 hold ignores a_in", 8'h00, 8'h00, 3'b010, 3'b111);
    chk("R5 b_out still stored", b_out, 8'h5A);
    // R3 chip enable high blocks driving
    step("R3 cen high", 8'h77, 8'h00, 3'b100, 3'b111);
    chk("R3 b_oe off", W'(b_oe), '0);
    // R6 chip enable high blocks loading
    step("R6 cen high le low", 8'h99, 8'h00, 3'b100, 3'b111);
    step("R6 recall", 8'h44, 8'h00, 3'b010, 3'b111);
    chk("R6 old value kept", b_out, 8'h5A);
    // R7 B-to-A
    step("R7 pass", 8'h00, 8'hC3, 3'b111, 3'b000);
    step("R7 hold", 8'h00, 8'h12, 3'b111, 3'b010);
    chk("R7 a_out stored", a_out, 8'hC3);
    // R9 one direction loads while other holds; R8 both drive
    step("R9 ab load ba hold", 8'h66, 8'hEE, 3'b000, 3'b010);
    chk("R9 a_out unaffected", a_out, 8'hC3);
    chk("R8 contention both drive", W'(contention), 8'h01);
    step("R9 ba load ab hold", 8'h01, 8'h2B, 3'b010, 3'b000);
    chk("R9 b_out unaffected", b_out, 8'h66);
    // R10 output disabled with transparent bank
    step("R10 oe high", 8'hF0, 8'h0F, 3'b001, 3'b001);
    chk("R10 b_out zero", b_out, 8'h00);
    chk("R10 a_out zero", a_out, 8'h00);

    // constrained random, chip enables biased low
    for (int i = 0; i < 600; i++) begin
      logic [2:0] abc, bac;
      abc = 3'($urandom);
      bac = 3'($urandom);
      if (($urandom % 4) != 0) abc[2] = 1'b0;
      if (($urandom % 4) != 0) bac[2] = 1'b0;
      step("rand R2-R10", 8'($urandom), 8'($urandom), abc, bac);
    end

    // R1 again: mid-run reset clears stored words
    @(negedge clk); rst_n = 1'b0;
    {ab_cen, ab_len, ab_oen} = 3'b010;
    {ba_cen, ba_len, ba_oen} = 3'b010;
    #1;
    chk("R1 mid-run b_out", b_out, 8'h00);
    chk("R1 mid-run a_out", a_out, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule